// File: doc/BRIEF.md
# Bidirectional Doorbell Interrupt Registers

This block lets two bus agents signal each other with doorbells. A local agent, such as an on-chip processor, sits on one side. An external agent, such as a device on a peripheral bus, sits on the other. The block holds two doorbell registers. The inbound register is rung by the external side and read and acknowledged by the local side. The outbound register is rung by the local side and acknowledged by the external side. In both registers the ringing side can only set bits, by writing ones, and the acknowledging side can only clear bits, by writing ones. Zero bits in a write leave the register as it was.

Any set inbound bit raises an active-high, level-sensitive interrupt toward the local side. Any set outbound bit pulls an active-low interrupt line toward the external side low. The external line is driven only while the doorbell enable bit of the enable register is one, and only the local side can write that bit. Each side has a plain register port with a write strobe, a register select, write data and combinational read data. The select codes are the same on both ports.

Top module: `doorbell_bridge`

## Requirements
- R1: An external-side write with select 0 (inbound) sets every inbound bit whose write-data bit is one, and leaves the other bits unchanged.
- R2: A local-side write with select 0 clears every inbound bit whose write-data bit is one, and leaves the other bits unchanged. A write of all zeros changes nothing.
- R3: A local-side write with select 1 (outbound) sets every outbound bit whose write-data bit is one, and leaves the other bits unchanged.
- R4: An external-side write with select 1 clears every outbound bit whose write-data bit is one, and leaves the other bits unchanged.
- R5: When a set from one side and a clear from the other side hit the same bit of the same register in the same cycle, the bit ends up set.
- R6: `loc_irq` equals the OR of all inbound bits as they stood before the previous clock edge. It is one register stage behind the inbound register.
- R7: `ext_irq_n` is low exactly when, before the previous clock edge, at least one outbound bit was set and the enable bit was one.
- R8: A local-side write with select 2 loads the enable bit from write-data bit 0. The enable register reads back with that bit at position 0 and zeros above it. External-side writes with select 2 have no effect.
- R9: Each side's read data shows, in the same cycle, the register picked by that side's select: 0 inbound, 1 outbound, 2 enable. Select 3 reads as zero, and writes with select 3 change nothing.
- R10: While reset is active, both doorbells and the enable bit are zero, `loc_irq` is 0 and `ext_irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_wr | input | 1 | Local-side write strobe |
| loc_sel | input | 2 | Local-side register select |
| loc_wdata | input | DB_W | Local-side write data |
| loc_rdata | output | DB_W | Local-side read data |
| ext_wr | input | 1 | External-side write strobe |
| ext_sel | input | 2 | External-side register select |
| ext_wdata | input | DB_W | External-side write data |
| ext_rdata | output | DB_W | External-side read data |
| loc_irq | output | 1 | Interrupt to the local side, active high |
| ext_irq_n | output | 1 | Interrupt to the external side, active low |

## Verification
A write takes effect at the clock edge that samples it. Both read ports show the new value from that edge on. The two interrupt outputs follow one edge later, because each is a register fed from the doorbell state. The bench drives its inputs on the falling edge and samples every output on the next falling edge. Its reference model computes the interrupt levels from the register values held before it applies the write, so each result is compared in the cycle it becomes due. Same-cycle set and clear on one bit, zero-data writes, enable gating and writes to the unused select are exercised directly. A seeded random run then covers mixed traffic from both sides.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef enum logic [1:0] {
    SEL_INBOUND  = 2'd0,
    SEL_OUTBOUND = 2'd1,
    SEL_ENABLE   = 2'd2,
    SEL_NONE     = 2'd3
  } db_sel_e;
endpackage

// File: rtl/db_w1_reg.sv
// Doorbell register cell: one side sets bits, the other clears them, set wins.
module db_w1_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/db_side_port.sv
// Per-side access port: turns a write into doorbell masks and muxes read data.
module db_side_port
  import doorbell_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         wr,
  input  logic [1:0]   sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] inb_q,
  input  logic [W-1:0] outb_q,
  input  logic         en_q,
  output logic [W-1:0] inb_mask,
  output logic [W-1:0] outb_mask,
  output logic [W-1:0] rdata
);
  db_sel_e sel_e;
  assign sel_e = db_sel_e'(sel);

  assign inb_mask  = (wr && sel_e == SEL_INBOUND)  ? wdata : '0;
  assign outb_mask = (wr && sel_e == SEL_OUTBOUND) ? wdata : '0;

  always_comb begin
    case (sel_e)
      SEL_INBOUND:  rdata = inb_q;
      SEL_OUTBOUND: rdata = outb_q;
      SEL_ENABLE:   rdata = {{(W-1){1'b0}}, en_q};
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/db_irq_out.sv
// Registered interrupt outputs for both directions.
module db_irq_out #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] inb_q,
  input  logic [W-1:0] outb_q,
  input  logic         en_q,
  output logic         loc_irq,
  output logic         ext_irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_irq   <= 1'b0;
      ext_irq_n <= 1'b1;
    end else begin
      loc_irq   <= |inb_q;
      ext_irq_n <= !((|outb_q) && en_q);
    end
  end
endmodule

// File: rtl/doorbell_bridge.sv
module doorbell_bridge
  import doorbell_pkg::*;
#(
  parameter int DB_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            loc_wr,
  input  logic [1:0]      loc_sel,
  input  logic [DB_W-1:0] loc_wdata,
  output logic [DB_W-1:0] loc_rdata,
  input  logic            ext_wr,
  input  logic [1:0]      ext_sel,
  input  logic [DB_W-1:0] ext_wdata,
  output logic [DB_W-1:0] ext_rdata,
  output logic            loc_irq,
  output logic            ext_irq_n
);
  logic [DB_W-1:0] inb_q, outb_q;
  logic            en_q;
  logic [DB_W-1:0] loc_inb_mask, loc_outb_mask;
  logic [DB_W-1:0] ext_inb_mask, ext_outb_mask;

  db_side_port #(.W(DB_W)) u_loc_port (
    .wr(loc_wr), .sel(loc_sel), .wdata(loc_wdata),
    .inb_q(inb_q), .outb_q(outb_q), .en_q(en_q),
    .inb_mask(loc_inb_mask), .outb_mask(loc_outb_mask), .rdata(loc_rdata)
  );

  db_side_port #(.W(DB_W)) u_ext_port (
    .wr(ext_wr), .sel(ext_sel), .wdata(ext_wdata),
    .inb_q(inb_q), .outb_q(outb_q), .en_q(en_q),
    .inb_mask(ext_inb_mask), .outb_mask(ext_outb_mask), .rdata(ext_rdata)
  );

  // Inbound: external side rings, local side acknowledges.
  db_w1_reg #(.W(DB_W)) u_inb (
    .clk(clk), .rst_n(rst_n),
    .set_mask(ext_inb_mask), .clr_mask(loc_inb_mask), .q(inb_q)
  );

  // Outbound: local side rings, external side acknowledges.
  db_w1_reg #(.W(DB_W)) u_outb (
    .clk(clk), .rst_n(rst_n),
    .set_mask(loc_outb_mask), .clr_mask(ext_outb_mask), .q(outb_q)
  );

  // Enable bit: written from the local side only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (loc_wr && db_sel_e'(loc_sel) == SEL_ENABLE) en_q <= loc_wdata[0];
  end

  db_irq_out #(.W(DB_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .inb_q(inb_q), .outb_q(outb_q), .en_q(en_q),
    .loc_irq(loc_irq), .ext_irq_n(ext_irq_n)
  );
endmodule

// File: rtl/db_checker.sv
module db_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         loc_wr,
  input logic [1:0]   loc_sel,
  input logic [W-1:0] loc_wdata,
  input logic         ext_wr,
  input logic [1:0]   ext_sel,
  input logic [W-1:0] ext_wdata,
  input logic         loc_irq,
  input logic         ext_irq_n,
  input logic [W-1:0] inb_q,
  input logic [W-1:0] outb_q,
  input logic         en_q
);
  AST_INB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr && ext_sel == 2'd0) |=> ((inb_q & $past(ext_wdata)) == $past(ext_wdata))); // R1

  AST_INB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && loc_sel == 2'd0 && !(ext_wr && ext_sel == 2'd0)) |=> ((inb_q & $past(loc_wdata)) == '0)); // R2

  AST_OUTB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && loc_sel == 2'd1) |=> ((outb_q & $past(loc_wdata)) == $past(loc_wdata))); // R3

  AST_OUTB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr && ext_sel == 2'd1 && !(loc_wr && loc_sel == 2'd1)) |=> ((outb_q & $past(ext_wdata)) == '0)); // R4

  AST_LOC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (loc_irq == (|$past(inb_q)))); // R6

  AST_EXT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ext_irq_n == !((|$past(outb_q)) && $past(en_q)))); // R7

  AST_EN_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_wr && loc_sel == 2'd2) |=> $stable(en_q)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_wr && !ext_wr) |=> ($stable(inb_q) && $stable(outb_q))); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (inb_q == '0 && outb_q == '0 && !en_q && !loc_irq && ext_irq_n)); // R10
endmodule

bind doorbell_bridge db_checker #(.W(DB_W)) u_db_checker (
  .clk(clk), .rst_n(rst_n),
  .loc_wr(loc_wr), .loc_sel(loc_sel), .loc_wdata(loc_wdata),
  .ext_wr(ext_wr), .ext_sel(ext_sel), .ext_wdata(ext_wdata),
  .loc_irq(loc_irq), .ext_irq_n(ext_irq_n),
  .inb_q(inb_q), .outb_q(outb_q), .en_q(en_q)
);

// File: tb/test_doorbell_bridge.sv
`timescale 1ns/1ps
module test_doorbell_bridge;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         loc_wr = 1'b0, ext_wr = 1'b0;
  logic [1:0]   loc_sel = 2'd0, ext_sel = 2'd0;
  logic [W-1:0] loc_wdata = '0, ext_wdata = '0;
  logic [W-1:0] loc_rdata, ext_rdata;
  logic         loc_irq, ext_irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference state
  logic [W-1:0] m_in = '0, m_out = '0;
  logic         m_en = 1'b0, m_irq = 1'b0, m_irq_n = 1'b1;

  always #10 clk = ~clk;

  doorbell_bridge #(.DB_W(W)) i_doorbell_bridge (
    .clk(clk), .rst_n(rst_n),
    .loc_wr(loc_wr), .loc_sel(loc_sel), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .ext_wr(ext_wr), .ext_sel(ext_sel), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .loc_irq(loc_irq), .ext_irq_n(ext_irq_n)
  );

  function automatic logic [W-1:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0:    return m_in;
      2'd1:    return m_out;
      2'd2:    return {{(W-1){1'b0}}, m_en};
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] apply_w1(input logic [W-1:0] q, input logic [W-1:0] s,
                                            input logic [W-1:0] c);
    return (q & ~c) | s;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic lw, input logic [1:0] ls, input logic [W-1:0] ld,
                      input logic ew, input logic [1:0] es, input logic [W-1:0] ed);
    logic [W-1:0] in_s, in_c, out_s, out_c;
    loc_wr = lw; loc_sel = ls; loc_wdata = ld;
    ext_wr = ew; ext_sel = es; ext_wdata = ed;
    @(posedge clk);
    m_irq   = |m_in;
    m_irq_n = !((|m_out) && m_en);
    in_s  = (ew && es == 2'd0) ? ed : '0;
    in_c  = (lw && ls == 2'd0) ? ld : '0;
    out_s = (lw && ls == 2'd1) ? ld : '0;
    out_c = (ew && es == 2'd1) ? ed : '0;
    m_in  = apply_w1(m_in, in_s, in_c);
    m_out = apply_w1(m_out, out_s, out_c);
    if (lw && ls == 2'd2) m_en = ld[0];
    @(negedge clk);
    check({tag, " loc read"}, loc_rdata, exp_rd(ls));
    check({tag, " ext read"}, ext_rdata, exp_rd(es));
    check("R6 loc_irq", {{(W-1){1'b0}}, loc_irq}, {{(W-1){1'b0}}, m_irq});
    check("R7 ext_irq_n", {{(W-1){1'b0}}, ext_irq_n}, {{(W-1){1'b0}}, m_irq_n});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state on both ports for every select
    for (int s = 0; s < 4; s++) begin
      loc_sel = 2'(s); ext_sel = 2'(3 - s);
      #1;
      check("R10 loc read", loc_rdata, '0);
      check("R10 ext read", ext_rdata, '0);
    end
    check("R10 loc_irq", {{(W-1){1'b0}}, loc_irq}, '0);
    check("R10 ext_irq_n", {{(W-1){1'b0}}, ext_irq_n}, {{(W-1){1'b0}}, 1'b1});
    rst_n = 1'b1;

    // R1: external rings inbound
    step("R1", 0, 2'd0, '0, 1, 2'd0, 32'h0000_0005);
    step("R6 idle", 0, 2'd0, '0, 0, 2'd0, '0);
    // R2: local acknowledges one bit, then a zero write
    step("R2", 1, 2'd0, 32'h0000_0001, 0, 2'd0, '0);
    step("R2 zero", 1, 2'd0, 32'h0000_0000, 0, 2'd0, '0);
    // R5: same-cycle set and clear on bit 4
    step("R5", 1, 2'd0, 32'h0000_0010, 1, 2'd0, 32'h0000_0010);
    check("R5 inbound", loc_rdata, 32'h0000_0014);
    step("R2 clear all", 1, 2'd0, 32'hFFFF_FFFF, 0, 2'd0, '0);
    step("R6 drop", 0, 2'd0, '0, 0, 2'd0, '0);
    check("R6 low", {{(W-1){1'b0}}, loc_irq}, '0);
    // R3: local rings outbound while disabled
    step("R3", 1, 2'd1, 32'h0000_00A0, 0, 2'd1, '0);
    step("R7 gated", 0, 2'd1, '0, 0, 2'd1, '0);
    check("R7 gated high", {{(W-1){1'b0}}, ext_irq_n}, {{(W-1){1'b0}}, 1'b1});
    // R8: external write to enable is ignored
    step("R8 ext ignored", 0, 2'd2, '0, 1, 2'd2, 32'hFFFF_FFFF);
    check("R8 enable still 0", ext_rdata, '0);
    step("R8 local load", 1, 2'd2, 32'hFFFF_FFFF, 0, 2'd2, '0);
    check("R8 enable reads 1", loc_rdata, 32'h0000_0001);
    step("R7 active", 0, 2'd1, '0, 0, 2'd1, '0);
    check("R7 low", {{(W-1){1'b0}}, ext_irq_n}, '0);
    // R5 on outbound: local set and external clear of bit 5
    step("R5 outbound", 1, 2'd1, 32'h0000_0020, 1, 2'd1, 32'h0000_0020);
    // R4: external acknowledges all
    step("R4", 0, 2'd1, '0, 1, 2'd1, 32'hFFFF_FFFF);
    check("R4 outbound", ext_rdata, '0);
    step("R7 release", 0, 2'd1, '0, 0, 2'd1, '0);
    // R9: select 3 reads zero and writes are ignored
    step("R9 sel3", 1, 2'd3, 32'hFFFF_FFFF, 1, 2'd3, 32'hFFFF_FFFF);
    step("R9 after", 0, 2'd0, '0, 0, 2'd1, '0);

    // Mixed random traffic, R9 read path plus all register rules
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] ld, ed;
      ld = $urandom(); ed = $urandom();
      if ($urandom_range(0, 3) == 0) ld = ld & ed;
      step("R9 random", 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), ld,
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), ed);
    end
    loc_wr = 1'b0; ext_wr = 1'b0;
    done = 1'b1;
    finish_run();
  end
endmodule